// File: doc/BRIEF.md
# Receive Descriptor Status Write-Back Engine

This block follows one received Ethernet frame as it is spread over a chain of receive descriptors. For each descriptor it produces the 32-bit status word that goes back to memory. Descriptors arrive one at a time. Each one carries two buffer sizes and an interrupt-on-completion request. Byte-transfer events then fill the descriptor's buffers. A descriptor is closed when its buffers are full or when the frame ends, whichever comes first.

On closure the engine builds the word and holds it on a request/acknowledge pair until the memory side accepts it. The word carries the ownership bit, the descriptor kind, the last mark, the status-valid bits, the error flags with their summary, the frame type and a byte count. After acceptance the engine may raise a one-cycle receive-complete interrupt or a one-cycle descriptor-error pulse. A descriptor whose fetched contents are all ones is not usable. The engine closes it with the error code, and the frame carries on in the next descriptor.

Top module: `rx_wb_engine`

## Requirements
- R1: Bit 31 of every write-back word is 0. While `wb_req` is high and `wb_ack` is low, `wb_req` stays high and `wb_data` does not change.
- R2: A descriptor whose 32-bit contents are all ones is written back as 32'h6000_0000, with bits 30 and 29 set and every other bit clear. `desc_err` then pulses for one cycle after the acknowledge, and `rx_irq` stays low. No frame bytes are counted against it, and the frame continues in the next descriptor with its running count intact.
- R3: Bit 29 (first mark, with bit 30 = 0) is set on the first non-error descriptor of a frame whose buffer capacity (size 1 + size 2) is non-zero. A zero first buffer still gives this mark when the second buffer is non-zero. A descriptor with both sizes 0 is closed at once as intermediate, with bit 29 = 0 and the running count, and the mark moves to the next descriptor.
- R4: When the bytes moved into a descriptor reach its capacity before the frame ends, the descriptor is written back with bit 28 = 0, bits 27:15 = 0, and bits 14:0 = the running byte total of the frame so far.
- R5: When the frame ends, the current descriptor is written back with bit 28 = 1. Bits 27:25 take the status-valid inputs. Bits 24..19 take the CRC, giant, watchdog, overflow, receive-error and dribble flags, in that order. Bits 18:16 take the frame type.
- R6: Bit 15 of the last word is the OR of the six error flags. When `parser_en` is 1 it also includes the destination and source filter-fail flags. When `parser_en` is 0 those two flags have no effect.
- R7: Bits 14:0 of the last word hold the total frame byte count. When `csum_en` is 1 and the frame type is not 3'b110 (MAC control), 2 is added to this count.
- R8: `rx_irq` pulses for exactly one cycle, in the cycle after a last-descriptor write-back is acknowledged, and only if that descriptor requested interrupt-on-completion.
- R9: The byte count saturates at 32767 instead of wrapping, both for the running count and for the final count.
- R10: After reset, `wb_req`, `rx_irq` and `desc_err` are 0 and `desc_ready` is 1.
- R11: If the frame ends in the same cycle that the buffers become full, the descriptor is written back as the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | A fetched descriptor is presented (taken when `desc_ready`) |
| desc_word | input | 32 | Raw descriptor contents, tested for all ones |
| desc_buf1_size | input | BUF_W | Size in bytes of the first buffer |
| desc_buf2_size | input | BUF_W | Size in bytes of the second buffer |
| desc_ioc | input | 1 | Interrupt-on-completion request of the descriptor |
| desc_ready | output | 1 | Engine is waiting for a descriptor |
| xfer_valid | input | 1 | Bytes of the frame were moved into the current buffers |
| xfer_bytes | input | XFER_W | Number of bytes moved |
| frame_end | input | 1 | The frame ends in this cycle; the flags below are sampled |
| err_crc | input | 1 | CRC error |
| err_giant | input | 1 | Frame exceeded the maximum size |
| err_wdog | input | 1 | Receive watchdog expired |
| err_ovf | input | 1 | Receive FIFO overflow |
| err_rx | input | 1 | Receive error from the line |
| err_dribble | input | 1 | Odd number of nibbles |
| filt_da_fail | input | 1 | Destination address filter failed |
| filt_sa_fail | input | 1 | Source address filter failed |
| frame_lt | input | 3 | Frame type code (3'b110 = MAC control) |
| stat_valid | input | 3 | Status-valid bits for bits 27:25 |
| parser_en | input | 1 | Filter failures join the error summary |
| csum_en | input | 1 | Checksum offload appends 2 bytes |
| wb_req | output | 1 | Write-back request |
| wb_data | output | 32 | Write-back status word |
| wb_ack | input | 1 | Write-back accepted |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| desc_err | output | 1 | Descriptor-error status pulse |

## Verification
The bench builds the engine with `BUF_W` = 14 and `XFER_W` = 12. A single descriptor can then hold 32766 bytes, and one transfer can move 4095 bytes. Nine transfers are therefore enough to push the running count past 32767, so saturation is reached in a short test. The same settings leave room for small buffers that fill in two to four beats, so the first, intermediate and last marks, coincident end-and-full, and zero-size descriptors all appear in short frames.

// File: rtl/rx_wb_engine.sv
module rx_wb_engine #(
  parameter int BUF_W  = 14,
  parameter int XFER_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [31:0]       desc_word,
  input  logic [BUF_W-1:0]  desc_buf1_size,
  input  logic [BUF_W-1:0]  desc_buf2_size,
  input  logic              desc_ioc,
  output logic              desc_ready,
  input  logic              xfer_valid,
  input  logic [XFER_W-1:0] xfer_bytes,
  input  logic              frame_end,
  input  logic              err_crc,
  input  logic              err_giant,
  input  logic              err_wdog,
  input  logic              err_ovf,
  input  logic              err_rx,
  input  logic              err_dribble,
  input  logic              filt_da_fail,
  input  logic              filt_sa_fail,
  input  logic [2:0]        frame_lt,
  input  logic [2:0]        stat_valid,
  input  logic              parser_en,
  input  logic              csum_en,
  output logic              wb_req,
  output logic [31:0]       wb_data,
  input  logic              wb_ack,
  output logic              rx_irq,
  output logic              desc_err
);

  localparam int CNT_W  = 15;
  localparam int CAP_W  = BUF_W + 1;
  localparam int FILL_W = ((CAP_W > XFER_W) ? CAP_W : XFER_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] LT_MACCTL = 3'b110;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WB} st_t;

  st_t               st_q;
  logic [CAP_W-1:0]  cap_q, cap_in;
  logic [FILL_W-1:0] fill_q, fill_sum;
  logic [CNT_W-1:0]  cnt_q, cnt_add, len_fin;
  logic [CNT_W:0]    raw_add, raw_fin;
  logic              first_q, ioc_q, last_q, err_q;
  logic              err_sum, full;
  logic [31:0]       last_word, mid_word, empty_word;

  assign desc_ready = (st_q == S_IDLE);
  assign wb_req     = (st_q == S_WB);

  assign cap_in   = CAP_W'(desc_buf1_size) + CAP_W'(desc_buf2_size);
  assign fill_sum = fill_q + (xfer_valid ? FILL_W'(xfer_bytes) : '0);
  assign full     = fill_sum >= FILL_W'(cap_q);

  assign raw_add = {1'b0, cnt_q} + (xfer_valid ? (CNT_W+1)'(xfer_bytes) : '0);
  assign cnt_add = raw_add[CNT_W] ? CNT_MAX : raw_add[CNT_W-1:0];
  assign raw_fin = {1'b0, cnt_add} +
                   ((csum_en && frame_lt != LT_MACCTL) ? (CNT_W+1)'(2) : '0);
  assign len_fin = raw_fin[CNT_W] ? CNT_MAX : raw_fin[CNT_W-1:0];

  assign err_sum = err_crc | err_giant | err_wdog | err_ovf | err_rx | err_dribble |
                   (parser_en & (filt_da_fail | filt_sa_fail));

  assign last_word  = {2'b00, first_q, 1'b1, stat_valid,
                       err_crc, err_giant, err_wdog, err_ovf, err_rx, err_dribble,
                       frame_lt, err_sum, len_fin};
  assign mid_word   = {2'b00, first_q, 14'b0, cnt_add};
  assign empty_word = {17'b0, cnt_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cap_q    <= '0;
      fill_q   <= '0;
      cnt_q    <= '0;
      first_q  <= 1'b1;
      ioc_q    <= 1'b0;
      last_q   <= 1'b0;
      err_q    <= 1'b0;
      wb_data  <= '0;
      rx_irq   <= 1'b0;
      desc_err <= 1'b0;
    end else begin
      rx_irq   <= 1'b0;
      desc_err <= 1'b0;
      unique case (st_q)
        S_IDLE: if (desc_valid) begin
          last_q <= 1'b0;
          ioc_q  <= 1'b0;
          fill_q <= '0;
          if (&desc_word) begin
            wb_data <= 32'h6000_0000;
            err_q   <= 1'b1;
            st_q    <= S_WB;
          end else if (cap_in == '0) begin
            wb_data <= empty_word;
            err_q   <= 1'b0;
            st_q    <= S_WB;
          end else begin
            cap_q <= cap_in;
            ioc_q <= desc_ioc;
            err_q <= 1'b0;
            st_q  <= S_ACT;
          end
        end
        S_ACT: begin
          if (frame_end) begin
            wb_data <= last_word;
            last_q  <= 1'b1;
            first_q <= 1'b1;
            cnt_q   <= '0;
            st_q    <= S_WB;
          end else if (xfer_valid) begin
            cnt_q  <= cnt_add;
            fill_q <= fill_sum;
            if (full) begin
              wb_data <= mid_word;
              first_q <= 1'b0;
              st_q    <= S_WB;
            end
          end
        end
        S_WB: if (wb_ack) begin
          rx_irq   <= last_q & ioc_q;
          desc_err <= err_q;
          st_q     <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_wb_engine_chk.sv
module rx_wb_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wb_req,
  input logic        wb_ack,
  input logic [31:0] wb_data,
  input logic        rx_irq,
  input logic        desc_err,
  input logic        desc_ready
);

  p_own_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !wb_data[31]);

  p_hold_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_data));

  p_err_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_data[30] |-> wb_data == 32'h6000_0000);

  p_err_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> $past(wb_req && wb_ack && wb_data[30]));

  p_mid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_data[28] |-> wb_data[27:15] == 13'd0);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(wb_req && wb_ack && wb_data[28]));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && desc_err));

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_ready && wb_req));

endmodule

bind rx_wb_engine rx_wb_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wb_req(wb_req), .wb_ack(wb_ack),
  .wb_data(wb_data), .rx_irq(rx_irq), .desc_err(desc_err),
  .desc_ready(desc_ready)
);

// File: tb/rx_wb_engine_test.sv
module rx_wb_engine_test;

  typedef struct packed {
    logic [13:0] b1;
    logic [13:0] b2;
    logic        ioc;
    logic [3:0]  beats;
    logic [11:0] bsz;
    logic        fend;
    logic [7:0]  flags;
    logic [2:0]  lt;
    logic [2:0]  rs;
    logic        parser;
    logic        csum;
    logic [31:0] exp_word;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{14'd0,  14'd64, 1'b0, 4'd4, 12'd16, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h2000_0040, 1'b0},
    '{14'd32, 14'd32, 1'b0, 4'd4, 12'd16, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0080, 1'b0},
    '{14'd64, 14'd64, 1'b1, 4'd2, 12'd20, 1'b1, 8'h00, 3'd1, 3'd7, 1'b0, 1'b1, 32'h1E01_00AA, 1'b1},
    '{14'd200,14'd0,  1'b0, 4'd1, 12'd60, 1'b1, 8'h80, 3'd6, 3'd1, 1'b0, 1'b1, 32'h3306_803C, 1'b0},
    '{14'd10, 14'd10, 1'b1, 4'd1, 12'd5,  1'b1, 8'h02, 3'd0, 3'd0, 1'b0, 1'b0, 32'h3000_0005, 1'b1},
    '{14'd8,  14'd8,  1'b0, 4'd1, 12'd8,  1'b1, 8'h01, 3'd4, 3'd0, 1'b1, 1'b0, 32'h3004_8008, 1'b0},
    '{14'd50, 14'd0,  1'b0, 4'd1, 12'd10, 1'b1, 8'h7C, 3'd0, 3'd0, 1'b0, 1'b0, 32'h30F8_800A, 1'b0},
    '{14'd16, 14'd0,  1'b1, 4'd2, 12'd8,  1'b1, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h3000_0010, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_ioc = 1'b0, xfer_valid = 1'b0, frame_end = 1'b0;
  logic [31:0] desc_word = '0;
  logic [13:0] desc_buf1_size = '0, desc_buf2_size = '0;
  logic [11:0] xfer_bytes = '0;
  logic [7:0]  flags = '0;
  logic [2:0]  frame_lt = '0, stat_valid = '0;
  logic parser_en = 1'b0, csum_en = 1'b0, wb_ack = 1'b0;
  logic desc_ready, wb_req, rx_irq, desc_err;
  logic [31:0] wb_data;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  rx_wb_engine #(.BUF_W(14), .XFER_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_word(desc_word),
    .desc_buf1_size(desc_buf1_size), .desc_buf2_size(desc_buf2_size),
    .desc_ioc(desc_ioc), .desc_ready(desc_ready), .xfer_valid(xfer_valid),
    .xfer_bytes(xfer_bytes), .frame_end(frame_end), .err_crc(flags[7]),
    .err_giant(flags[6]), .err_wdog(flags[5]), .err_ovf(flags[4]),
    .err_rx(flags[3]), .err_dribble(flags[2]), .filt_da_fail(flags[1]),
    .filt_sa_fail(flags[0]), .frame_lt(frame_lt), .stat_valid(stat_valid),
    .parser_en(parser_en), .csum_en(csum_en), .wb_req(wb_req),
    .wb_data(wb_data), .wb_ack(wb_ack), .rx_irq(rx_irq), .desc_err(desc_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic do_desc(input vec_t v, input logic ones, input logic exp_err, input int hold);
    logic [31:0] seen;
    int waited;
    @(negedge clk);
    check("R10 ready before descriptor", {31'b0, desc_ready}, 32'd1);
    desc_valid = 1'b1;
    desc_word = ones ? 32'hFFFF_FFFF : 32'h0;
    desc_buf1_size = v.b1; desc_buf2_size = v.b2; desc_ioc = v.ioc;
    @(negedge clk);
    desc_valid = 1'b0; desc_word = '0;
    parser_en = v.parser; csum_en = v.csum;
    for (int i = 0; i < int'(v.beats); i++) begin
      xfer_valid = 1'b1; xfer_bytes = v.bsz;
      if (v.fend && i == int'(v.beats) - 1) begin
        frame_end = 1'b1; flags = v.flags; frame_lt = v.lt; stat_valid = v.rs;
      end
      @(negedge clk);
      xfer_valid = 1'b0; frame_end = 1'b0; flags = '0;
    end
    if (v.beats == 4'd0 && v.fend) begin
      frame_end = 1'b1; flags = v.flags; frame_lt = v.lt; stat_valid = v.rs;
      @(negedge clk);
      frame_end = 1'b0; flags = '0;
    end
    waited = 0;
    while (!wb_req && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check("R1 write-back requested", {31'b0, wb_req}, 32'd1);
    check("word R2 R3 R4 R5 R6 R7 R9 R11", wb_data, v.exp_word);
    seen = wb_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R1 held request", {31'b0, wb_req}, 32'd1);
      check("R1 stable word", wb_data, seen);
    end
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    check("R8 irq after ack", {31'b0, rx_irq}, {31'b0, v.exp_irq});
    check("R2 desc_err after ack", {31'b0, desc_err}, {31'b0, exp_err});
    @(negedge clk);
    check("R8 irq one cycle", {30'b0, rx_irq, desc_err}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {29'b0, wb_req, rx_irq, desc_err}, 32'd0);
    check("R10 reset ready", {31'b0, desc_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {28'b0, desc_ready, wb_req, rx_irq, desc_err}, 32'h8);

    // R3 both sizes zero, R2 all-ones with delayed ack, then first mark lands later
    do_desc('{14'd0, 14'd0, 1'b1, 4'd0, 12'd0, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0000_0000, 1'b0}, 1'b0, 1'b0, 0);
    do_desc('{14'd5, 14'd5, 1'b1, 4'd0, 12'd0, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h6000_0000, 1'b0}, 1'b1, 1'b1, 3);
    do_desc('{14'd20, 14'd0, 1'b1, 4'd1, 12'd12, 1'b1, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h3000_000C, 1'b1}, 1'b0, 1'b0, 0);

    // R2 error descriptor in the middle of a frame keeps the running count
    do_desc('{14'd8, 14'd0, 1'b0, 4'd1, 12'd8, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h2000_0008, 1'b0}, 1'b0, 1'b0, 0);
    do_desc('{14'd8, 14'd0, 1'b1, 4'd0, 12'd0, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h6000_0000, 1'b0}, 1'b1, 1'b1, 0);
    do_desc('{14'd8, 14'd0, 1'b0, 4'd1, 12'd4, 1'b1, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h1000_000C, 1'b0}, 1'b0, 1'b0, 1);

    for (int k = 0; k < NV; k++) do_desc(TBL[k], 1'b0, 1'b0, 0);

    // R9 saturation of running and final counts
    do_desc('{14'd16383, 14'd16383, 1'b0, 4'd9, 12'd4095, 1'b0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 32'h2000_7FFF, 1'b0}, 1'b0, 1'b0, 0);
    do_desc('{14'd100, 14'd0, 1'b1, 4'd1, 12'd10, 1'b1, 8'h00, 3'd0, 3'd0, 1'b0, 1'b1, 32'h1000_7FFF, 1'b1}, 1'b0, 1'b0, 0);

    finish_up();
  end

endmodule